// File: doc/BRIEF.md
# Multi-Channel Standalone Pattern Checker

This block runs a bit-error test on any one of six receive lanes, or on all six at once. The lanes that are not under test keep carrying their normal traffic. Each lane delivers one 10-bit word per clock together with an active-low lock flag. An activate input starts and stops the test, and that input is filtered so that a level must persist for several clocks before it counts. A 3-bit select picks the lanes under test. A mode input picks one of two ways to report errors. In the sticky summary mode, a lane's whole output word latches high at its first error. In the per-bit mode, each output bit flags a mismatch in the matching bit of the current word only.

The expected data is a pseudo-random sequence generated by x^15 + x^14 + 1, ten bits per word. The checker takes its starting state from the first two words a lane delivers after the test begins. From the third word on it compares each received word against the prediction and counts the wrong bits. After a fixed number of checked words, the lane raises a done flag. It also sets a pass flag when the error count is within the allowed bit-error ratio. Both flags of all six lanes are packed into a 12-bit status word.

Top module: `bist_standalone`

## Requirements
- R1: A new level on `tst_act` takes effect only after it has been sampled on DEB (default 4) consecutive rising clock edges. With the default, the lane's outputs change one edge after the fourth such edge. A shorter pulse changes nothing. Stopping the test follows the same rule.
- R2: While the test is on, select code c (0 to 5) tests only lane c, code 6 tests all lanes, and code 7 tests no lane.
- R3: A lane not under test copies its received word to `out_data` and its lock flag to `out_lock_n`, with one clock of latency.
- R4: A lane under test drives its `out_lock_n` bit to 0 from the first clock it is in test. The lane outputs all-zero data for its first two words, which seed the checker.
- R5: In summary mode (`tst_bitmode`=0), a lane's 10 output bits all go to 1 in the cycle of its first wrong bit. They stay at 1 until the lane leaves test. A new test starts from 0 again.
- R6: In per-bit mode (`tst_bitmode`=1), output bit k of a lane is 1 exactly when bit k of that clock's received word differs from the expected word. It is not sticky.
- R7: Status bit 2c+1 is lane c's done flag and bit 2c is its pass flag, so lane 5 sits in the top two bits. Both flags clear when the lane enters test and hold their value while it is out of test.
- R8: Done sets when the lane's checked-word count reaches CHECK_WORDS. Pass is set at the same time if the bit-error count over those words is at most floor(CHECK_WORDS*10/BER_DEN); otherwise pass stays 0. With the default BER_DEN, this limit is a bit-error ratio of 1e-7.
- R9: Word bit 9 is the earliest bit of the sequence in time, and bit 0 is the latest. Each new bit is the XOR of the bits 15 and 14 places back. The two seed words provide the first 15 bits of history.
- R10: During reset, `out_data` is 0, `out_lock_n` is all ones, `status` is 0 and the test is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tst_act | input | 1 | Test activate request, filtered |
| tst_sel | input | 3 | Lane select: 0-5 one lane, 6 all, 7 none |
| tst_bitmode | input | 1 | 0 sticky summary report, 1 per-bit report |
| rx_data | input | NCH*W | Received words, lane c at bits c*W+W-1 : c*W |
| rx_lock_n | input | NCH | Received lock flags, active low |
| out_data | output | NCH*W | Traffic or error report per lane |
| out_lock_n | output | NCH | Lock flags, forced low for lanes under test |
| status | output | 2*NCH | Per lane {done, pass}, lane 5 at the top |

## Verification
Clean sequence words on a lane under test must give all-zero reports. This separates a correct predictor and seed from one that mismatches at every word. Sparse random error masks in per-bit mode show whether each output bit follows its own received bit and does not latch. Single-bit errors in summary mode show that one bad bit sets the whole word and that it stays set. Four errors against five errors, at a limit of four, split the pass and fail outcomes at the boundary of R8. Random traffic with random lock flags on the untested lanes, in each select code, shows that the lanes outside the test are never disturbed.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  typedef enum logic [1:0] {
    LN_LOAD  = 2'd0,
    LN_SEED  = 2'd1,
    LN_CHECK = 2'd2
  } lane_phase_e;

  localparam int          SEL_W   = 3;
  localparam logic [2:0]  SEL_ALL = 3'd6;
  localparam int          PN_LEN  = 15;

  // allowed bit errors for a given number of checked bits
  function automatic longint ber_limit(input longint bits, input longint den);
    return bits / den;
  endfunction

endpackage

// File: rtl/bist_act_filter.sv
module bist_act_filter #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic flip
);
  localparam int CNT_W = $clog2(DEB + 1);

  logic [CNT_W-1:0] run_q;

  assign flip = (raw != level) && (run_q == CNT_W'(DEB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      run_q <= '0;
    end else if (raw == level) begin
      run_q <= '0;
    end else if (flip) begin
      level <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bist_lane.sv
module bist_lane
  import bist_chk_pkg::*;
#(
  parameter int W           = 10,
  parameter int CHECK_WORDS = 2000000,
  parameter int BER_DEN     = 10000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bitmode,
  input  logic [W-1:0] rx_word,
  input  logic         rx_lock_n,
  output logic [W-1:0] out_word,
  output logic         out_lock_n,
  output logic         done,
  output logic         pass
);
  localparam int          CW         = $clog2(CHECK_WORDS + 1);
  localparam longint      TOTAL_BITS = longint'(CHECK_WORDS) * longint'(W);
  localparam int          EW         = $clog2(TOTAL_BITS + 1);
  localparam logic [EW-1:0] LIM_V    = EW'(ber_limit(TOTAL_BITS, longint'(BER_DEN)));
  localparam int          HI         = PN_LEN - W;   // bits kept from the first seed word

  // advance the sequence by one word: returns {word, new state}
  function automatic logic [W+PN_LEN-1:0] pn_step(input logic [PN_LEN-1:0] s);
    logic [PN_LEN-1:0] st;
    logic [W-1:0]      wd;
    logic              nb;
    st = s;
    wd = '0;
    for (int i = 0; i < W; i++) begin
      nb = st[PN_LEN-1] ^ st[PN_LEN-2];
      st = {st[PN_LEN-2:0], nb};
      wd[W-1-i] = nb;
    end
    return {wd, st};
  endfunction

  lane_phase_e        phase_q;
  logic [HI-1:0]      first_q;
  logic [W-1:0]       exp_q;
  logic [PN_LEN-1:0]  pn_q;
  logic               sticky_q;
  logic [CW-1:0]      wcnt_q;
  logic [EW-1:0]      ecnt_q;

  logic [PN_LEN-1:0]  seed_state;
  logic [W+PN_LEN-1:0] seed_gen, run_gen;
  logic [W-1:0]       diff;
  logic               word_bad;
  logic [EW-1:0]      ecnt_sum;
  logic               last_word;

  always_comb begin
    seed_state = {first_q, rx_word};
    seed_gen   = pn_step(seed_state);
    run_gen    = pn_step(pn_q);
    diff       = (phase_q == LN_CHECK) ? (rx_word ^ exp_q) : '0;
    word_bad   = |diff;
    ecnt_sum   = ecnt_q + EW'($countones(diff));
    last_word  = (wcnt_q == CW'(CHECK_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= LN_LOAD;
      first_q    <= '0;
      exp_q      <= '0;
      pn_q       <= '0;
      sticky_q   <= 1'b0;
      wcnt_q     <= '0;
      ecnt_q     <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      out_word   <= '0;
      out_lock_n <= 1'b1;
    end else if (!en) begin
      phase_q    <= LN_LOAD;
      sticky_q   <= 1'b0;
      out_word   <= rx_word;
      out_lock_n <= rx_lock_n;
    end else begin
      out_lock_n <= 1'b0;
      case (phase_q)
        LN_LOAD: begin
          first_q  <= rx_word[HI-1:0];
          sticky_q <= 1'b0;
          wcnt_q   <= '0;
          ecnt_q   <= '0;
          done     <= 1'b0;
          pass     <= 1'b0;
          out_word <= '0;
          phase_q  <= LN_SEED;
        end
        LN_SEED: begin
          {exp_q, pn_q} <= seed_gen;
          out_word      <= '0;
          phase_q       <= LN_CHECK;
        end
        LN_CHECK: begin
          {exp_q, pn_q} <= run_gen;
          sticky_q      <= sticky_q | word_bad;
          out_word      <= bitmode ? diff : {W{sticky_q | word_bad}};
          if (!done) begin
            wcnt_q <= wcnt_q + CW'(1);
            ecnt_q <= ecnt_sum;
            if (last_word) begin
              done <= 1'b1;
              pass <= (ecnt_sum <= LIM_V);
            end
          end
        end
        default: phase_q <= LN_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/bist_standalone.sv
module bist_standalone
  import bist_chk_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int W           = 10,
  parameter int DEB         = 4,
  parameter int CHECK_WORDS = 2000000,
  parameter int BER_DEN     = 10000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tst_act,
  input  logic [SEL_W-1:0] tst_sel,
  input  logic             tst_bitmode,
  input  logic [NCH*W-1:0] rx_data,
  input  logic [NCH-1:0]   rx_lock_n,
  output logic [NCH*W-1:0] out_data,
  output logic [NCH-1:0]   out_lock_n,
  output logic [2*NCH-1:0] status
);
  logic           test_on;
  logic           act_flip;
  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] lane_done, lane_pass;

  bist_act_filter #(.DEB(DEB)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (tst_act),
    .level (test_on),
    .flip  (act_flip)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign chan_en[c] = test_on && ((tst_sel == SEL_W'(c)) || (tst_sel == SEL_ALL));

    bist_lane #(
      .W(W), .CHECK_WORDS(CHECK_WORDS), .BER_DEN(BER_DEN)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (chan_en[c]),
      .bitmode    (tst_bitmode),
      .rx_word    (rx_data[c*W +: W]),
      .rx_lock_n  (rx_lock_n[c]),
      .out_word   (out_data[c*W +: W]),
      .out_lock_n (out_lock_n[c]),
      .done       (lane_done[c]),
      .pass       (lane_pass[c])
    );

    assign status[2*c+1] = lane_done[c];
    assign status[2*c]   = lane_pass[c];
  end

  logic unused_ok;
  assign unused_ok = act_flip;
endmodule

// File: rtl/bist_standalone_chk.sv
module bist_standalone_chk #(
  parameter int NCH = 6,
  parameter int W   = 10,
  parameter int DEB = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tst_act,
  input logic [2:0]       tst_sel,
  input logic             tst_bitmode,
  input logic [NCH*W-1:0] rx_data,
  input logic [NCH-1:0]   rx_lock_n,
  input logic [NCH*W-1:0] out_data,
  input logic [NCH-1:0]   out_lock_n,
  input logic [2*NCH-1:0] status,
  input logic             test_on,
  input logic [NCH-1:0]   chan_en
);
  localparam int RW = $clog2(DEB + 1) + 1;
  logic [RW-1:0] run_hi, run_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_hi <= '0;
      run_lo <= '0;
    end else begin
      run_hi <= tst_act ? ((run_hi < RW'(DEB)) ? run_hi + RW'(1) : run_hi) : '0;
      run_lo <= !tst_act ? ((run_lo < RW'(DEB)) ? run_lo + RW'(1) : run_lo) : '0;
    end
  end

  AST_START_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_on) |-> run_hi >= RW'(DEB)); // R1
  AST_STOP_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_on) |-> run_lo >= RW'(DEB)); // R1
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_sel == 3'd7) |=> out_lock_n == $past(rx_lock_n)); // R2

  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |=> out_data[c*W +: W] == $past(rx_data[c*W +: W])); // R3
    AST_LOCK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en[c] |=> !out_lock_n[c]); // R4
    AST_GROSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[c] && $past(chan_en[c]) && !tst_bitmode && (&out_data[c*W +: W]))
        |=> (&out_data[c*W +: W])); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |=> $stable(status[2*c +: 2])); // R7
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      status[2*c] |-> status[2*c+1]); // R8
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (status == '0 && out_data == '0 && &out_lock_n))); // R10
endmodule

bind bist_standalone bist_standalone_chk #(.NCH(NCH), .W(W), .DEB(DEB)) u_chk (.*);

// File: tb/bist_standalone_test.sv
module bist_standalone_test;
  localparam int NCH = 6;
  localparam int W   = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tst_act;
  logic [2:0]       tst_sel;
  logic             tst_bitmode;
  logic [NCH*W-1:0] rx_data;
  logic [NCH-1:0]   rx_lock_n;
  logic [NCH*W-1:0] out_data;
  logic [NCH-1:0]   out_lock_n;
  logic [2*NCH-1:0] status;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [14:0] gen_h [NCH];
  logic [W-1:0] drv   [NCH];
  logic [W-1:0] emask [NCH];
  logic [NCH-1:0] prev_lock;

  always #4 clk = ~clk;

  bist_standalone #(.CHECK_WORDS(40), .BER_DEN(100)) uut (.*);

  // bench sequence: h[0] is 15 bits back, h[14] the newest
  task automatic pn_word(input int c, output logic [W-1:0] w);
    logic nb;
    for (int i = 0; i < W; i++) begin
      nb = gen_h[c][0] ^ gen_h[c][1];
      gen_h[c] = {nb, gen_h[c][14:1]};
      w[W-1-i] = nb;
    end
  endtask

  task automatic tick();
    logic [W-1:0] w;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      pn_word(c, w);
      drv[c] = w ^ emask[c];
      rx_data[c*W +: W] = drv[c];
      emask[c] = '0;
    end
    prev_lock = rx_lock_n;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic through(input int c, input string tag);
    check(tag, 32'(out_data[c*W +: W]), 32'(drv[c]));
    check(tag, 32'(out_lock_n[c]), 32'(prev_lock[c]));
  endtask

  task automatic start_test(input logic [2:0] sel, input logic mode);
    tst_sel = sel;
    tst_bitmode = mode;
    tst_act = 1'b1;
    for (int t = 1; t <= 4; t++) tick();
    if (sel != 3'd7) check("R1 lock before 5th edge", 32'(out_lock_n[sel == 3'd6 ? 0 : int'(sel)]), 32'd1);
  endtask

  task automatic stop_test();
    tst_act = 1'b0;
    for (int t = 1; t <= 5; t++) tick();
  endtask

  initial begin
    int errs;
    logic [W-1:0] m;
    void'($urandom(32'd4711));
    rst_n = 1'b0; tst_act = 1'b0; tst_sel = 3'd7; tst_bitmode = 1'b0;
    rx_data = '0; rx_lock_n = '1;
    for (int c = 0; c < NCH; c++) begin
      gen_h[c] = 15'h1ACE ^ 15'(c * 97);
      emask[c] = '0;
    end
    tick(); tick();
    // reset state
    check("R10 status", 32'(status), 32'd0);
    check("R10 data", 32'(out_data[31:0]), 32'd0);
    check("R10 lock", 32'(out_lock_n), 32'h3f);
    rst_n = 1'b1;

    // idle traffic with random lock flags
    for (int t = 0; t < 6; t++) begin
      rx_lock_n = 6'($urandom);
      tick();
      for (int c = 0; c < NCH; c++) through(c, "R3 idle pass");
    end
    rx_lock_n = '1;

    // too-short activate pulse
    tst_sel = 3'd2; tst_act = 1'b1;
    tick(); tick(); tick();
    tst_act = 1'b0;
    for (int t = 0; t < 6; t++) begin
      tick();
      check("R1 short pulse lock", 32'(out_lock_n[2]), 32'd1);
    end

    // lane 2, per-bit mode, random errors
    start_test(3'd2, 1'b1);
    errs = 0;
    for (int t = 5; t <= 50; t++) begin
      m = '0;
      if (t >= 9 && t <= 30 && $urandom_range(0, 2) == 0) m = 10'($urandom);
      emask[2] = m;
      if (t <= 46) errs += $countones(m);
      rx_lock_n = 6'($urandom) | 6'b000100;
      tick();
      check("R4 lock low", 32'(out_lock_n[2]), 32'd0);
      if (t <= 6) check("R4 seed output zero", 32'(out_data[2*W +: W]), 32'd0);
      else check("R6 R9 per-bit report", 32'(out_data[2*W +: W]), 32'(m));
      for (int c = 0; c < NCH; c++) if (c != 2) through(c, "R2 R3 other lanes");
      if (t == 45) check("R8 not done yet", 32'(status[5]), 32'd0);
      if (t == 46) check("R8 done on last word", 32'(status[5:4]), {30'd0, 1'b1, errs <= 4});
    end
    rx_lock_n = '1;
    tst_act = 1'b0;
    for (int t = 1; t <= 4; t++) tick();
    check("R1 stop filtered", 32'(out_lock_n[2]), 32'd0);
    tick();
    through(2, "R1 R3 lane back to traffic");
    check("R7 status held", 32'(status[5:4]), {30'd0, 1'b1, errs <= 4});

    // lane 0, summary mode, four errors: pass at the limit
    start_test(3'd0, 1'b0);
    for (int t = 5; t <= 50; t++) begin
      if (t == 10 || t == 15 || t == 20 || t == 25) emask[0] = 10'h1 << (t % 10);
      tick();
      check("R5 summary report", 32'(out_data[W-1:0]), (t >= 10) ? 32'h3ff : 32'd0);
    end
    check("R8 R7 four errors pass", 32'(status[1:0]), 32'd3);
    stop_test();
    through(0, "R3 after summary test");

    // all lanes, five errors on lane 5: fail at the limit
    start_test(3'd6, 1'b0);
    for (int t = 5; t <= 50; t++) begin
      if (t >= 10 && t <= 14) emask[5] = 10'h200 >> (t - 10);
      if (t == 20) tst_bitmode = 1'b1;
      tick();
      check("R2 all lanes locked", 32'(out_lock_n), 32'd0);
      if (t == 7) check("R5 cleared on new test", 32'(out_data[W-1:0]), 32'd0);
      if (t == 19) check("R5 sticky", 32'(out_data[5*W +: W]), 32'h3ff);
      if (t == 20) check("R6 not sticky", 32'(out_data[5*W +: W]), 32'd0);
    end
    check("R7 R8 status word", 32'(status), 32'b10_11_11_11_11_11);
    stop_test();

    // idle code tests nothing
    start_test(3'd7, 1'b0);
    for (int t = 0; t < 8; t++) begin
      rx_lock_n = 6'($urandom);
      tick();
      for (int c = 0; c < NCH; c++) through(c, "R2 idle code");
    end
    check("R7 status kept", 32'(status), 32'b10_11_11_11_11_11);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule